// File: doc/BRIEF.md
# Cache Range Maintenance Sequencer

This block walks a physical address range that software describes through a small register write port, one cache line at a time. For each line it asks a directory for the line's state. It then either issues one coherence transaction for the line or skips the line. In invalidate mode the transaction is a multicast or broadcast invalidation. In sync mode it is a write-back of dirty data.

Two counters govern the walk. The first holds the lines still to be examined. The second holds the issued transactions whose completions have not yet come back. The second counter is a single up/down register. The issue path increments it. Two independent completion pulses decrement it, and those pulses may arrive in the same cycle. The operation finishes only when both counters are zero. At that point a one-cycle done pulse is produced and the block returns to idle. A start request that arrives while a walk is in progress is refused.

Top module: `range_maint_seq`

## Requirements
- R1: On start, the line counter is loaded with the range length divided by the line size in bytes (LINE_WORDS x 4), rounded up when a remainder is left. A length of 0 yields 0 lines.
- R2: The walk begins at the start address with its low log2(line bytes) bits cleared. Lines are visited in ascending order, each one line size above the previous. The outstanding counter reads 0 right after start.
- R3: The outstanding counter rises by one on each accepted transaction and falls by one on a cycle with either completion pulse. A cycle with both pulses and no accept falls by only one. A cycle with an accept and any pulse leaves it unchanged.
- R4: A line needs no transaction, and does not touch the outstanding counter, in these cases: a directory miss, an invalidate-mode hit with zero copies, or a sync-mode hit that is clean. The line counter still decrements for such a line.
- R5: The txn_kind encoding is 0 for a multicast invalidation, 1 for a broadcast invalidation and 2 for a sync write-back. An invalidate-mode line uses code 1 when its copy count exceeds BCAST_MIN, and code 0 otherwise.
- R6: done pulses high for exactly one cycle, in the same cycle that active falls. This happens only after both counters are zero, and every line that needs a transaction has been issued by then.
- R7: A start write made while active is high sets cfg_reject on the next cycle and leaves the walk in progress unaffected.
- R8: While txn_valid is high and txn_ready is low, txn_valid, txn_addr and txn_kind hold steady.
- R9: After reset, active, done, txn_valid, dir_req and cfg_reject are low, and lines_left and pending are zero.

Register select codes on cfg_wr_sel:
- 0: address bits 31:0.
- 1: upper address bits.
- 2: length in bytes.
- 3: mode, where bit 0 = 1 selects sync.
- 4: start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 3 | Register select |
| cfg_wr_data | input | 32 | Register write data |
| cfg_reject | output | 1 | Start refused because a walk is active |
| dir_req | output | 1 | Directory lookup request |
| dir_addr | output | ADDR_W | Line address under lookup |
| dir_ack | input | 1 | Lookup result valid |
| dir_hit | input | 1 | Line present in directory |
| dir_copies | input | COPIES_W | Number of cached copies |
| dir_dirty | input | 1 | Line holds modified data |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Transaction accepted |
| txn_addr | output | ADDR_W | Line address of transaction |
| txn_kind | output | 2 | Transaction kind code |
| rsp_inval_done | input | 1 | Invalidation completion pulse |
| rsp_sync_done | input | 1 | Write-back completion pulse |
| active | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| lines_left | output | LEN_W-log2(line bytes)+1 | Lines not yet examined |
| pending | output | PEND_W | Outstanding transactions |

## Verification
Assertions check the following on every cycle:
- the up/down rules of the outstanding counter, including the dual-pulse and simultaneous accept-and-complete cases, together with overflow and underflow guards;
- transaction stability under backpressure;
- refusal of a start made while busy;
- the idle state that accompanies done.

The bench scenarios are needed for behaviour that depends on the whole walk:
- the line count with rounding;
- the aligned, ascending address order;
- which lines are skipped;
- the choice between broadcast and multicast;
- the guarantee that done arrives only after every needed transaction has been issued and drained.

// File: rtl/rms_pkg.sv
package rms_pkg;

   typedef enum logic [1:0] {
      KIND_MCAST = 2'd0,
      KIND_BCAST = 2'd1,
      KIND_SYNC  = 2'd2
   } txn_kind_e;

   typedef enum logic [1:0] {
      WS_IDLE   = 2'd0,
      WS_LOOP   = 2'd1,
      WS_LOOKUP = 2'd2,
      WS_ISSUE  = 2'd3
   } walk_state_e;

   localparam logic [2:0] SEL_ADDR_LO = 3'd0;
   localparam logic [2:0] SEL_ADDR_HI = 3'd1;
   localparam logic [2:0] SEL_LENGTH  = 3'd2;
   localparam logic [2:0] SEL_MODE    = 3'd3;
   localparam logic [2:0] SEL_GO      = 3'd4;

endpackage

// File: rtl/rms_cfg_regs.sv
module rms_cfg_regs
   import rms_pkg::*;
#(
   parameter int ADDR_W  = 40,
   parameter int LEN_W   = 32,
   parameter int LINE_SH = 6,
   parameter int LINES_W = LEN_W - LINE_SH + 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [2:0]         wr_sel,
   input  logic [31:0]        wr_data,
   input  logic               busy,
   output logic               start_go,
   output logic               reject,
   output logic               op_sync,
   output logic [ADDR_W-1:0]  base_addr,
   output logic [LINES_W-1:0] line_total
);

   logic [31:0]       lo_q;
   logic [LEN_W-1:0]  len_q;
   logic              mode_q;
   logic              reject_q;
   logic [ADDR_W-1:0] full_addr;
   logic              go_wr;
   logic              frac;

   assign go_wr = wr_en && (wr_sel == SEL_GO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q     <= '0;
         len_q    <= '0;
         mode_q   <= 1'b0;
         reject_q <= 1'b0;
      end else begin
         reject_q <= go_wr && busy;
         if (wr_en && wr_sel == SEL_ADDR_LO) lo_q   <= wr_data;
         if (wr_en && wr_sel == SEL_LENGTH)  len_q  <= wr_data[LEN_W-1:0];
         if (wr_en && wr_sel == SEL_MODE)    mode_q <= wr_data[0];
      end
   end

   generate
      if (ADDR_W > 32) begin : g_hi
         logic [ADDR_W-33:0] hi_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                              hi_q <= '0;
            else if (wr_en && wr_sel == SEL_ADDR_HI) hi_q <= wr_data[ADDR_W-33:0];
         end
         assign full_addr = {hi_q, lo_q};
      end else begin : g_lo_only
         assign full_addr = lo_q;
      end
   endgenerate

   // Partial-line remainder rounds the count up
   assign frac       = |len_q[LINE_SH-1:0];
   assign line_total = {1'b0, len_q[LEN_W-1:LINE_SH]} + LINES_W'(frac);
   assign base_addr  = {full_addr[ADDR_W-1:LINE_SH], {LINE_SH{1'b0}}};
   assign start_go   = go_wr && !busy;
   assign reject     = reject_q;
   assign op_sync    = mode_q;

   assert_reject_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (go_wr && busy) |=> reject);
   assert_no_reject_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(go_wr && busy) |=> !reject);

endmodule

// File: rtl/rms_resp_counter.sv
module rms_resp_counter #(
   parameter int W = 8
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         inc,
   input  logic         dec_a,
   input  logic         dec_b,
   output logic [W-1:0] count,
   output logic         is_zero
);

   logic         dec_any;
   logic [W-1:0] cnt_q;

   assign dec_any = dec_a || dec_b;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clear)          cnt_q <= '0;
      else if (inc && !dec_any) cnt_q <= cnt_q + W'(1);
      else if (!inc && dec_any) cnt_q <= cnt_q - W'(1);
   end

   assign count   = cnt_q;
   assign is_zero = (cnt_q == '0);

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && inc && !dec_any) |-> (cnt_q != '1));
   assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !inc && dec_any) |-> (cnt_q != '0));
   assert_cancel_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && inc && dec_any) |=> (count == $past(count)));
   assert_dual_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !inc && dec_a && dec_b) |=> (count == $past(count) - W'(1)));
   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> is_zero);

endmodule

// File: rtl/rms_walker.sv
module rms_walker
   import rms_pkg::*;
#(
   parameter int ADDR_W    = 40,
   parameter int LINE_SH   = 6,
   parameter int LINES_W   = 27,
   parameter int COPIES_W  = 8,
   parameter int BCAST_MIN = 4,
   parameter bit BCAST_EN  = 1'b1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_go,
   input  logic                op_sync,
   input  logic [ADDR_W-1:0]   base_addr,
   input  logic [LINES_W-1:0]  line_total,
   input  logic                pending_zero,
   input  logic                dir_ack,
   input  logic                dir_hit,
   input  logic [COPIES_W-1:0] dir_copies,
   input  logic                dir_dirty,
   input  logic                txn_ready,
   output logic                busy,
   output logic                dir_req,
   output logic [ADDR_W-1:0]   dir_addr,
   output logic                txn_valid,
   output logic [ADDR_W-1:0]   txn_addr,
   output logic [1:0]          txn_kind,
   output logic                issue_fire,
   output logic [LINES_W-1:0]  lines_left,
   output logic                done
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << LINE_SH;

   walk_state_e       st_q;
   logic [LINES_W-1:0] lines_q;
   logic [ADDR_W-1:0] addr_q;
   txn_kind_e         kind_q;
   logic              op_q;
   logic              done_q;
   logic              need;
   txn_kind_e         inval_kind;
   txn_kind_e         kind_sel;

   generate
      if (BCAST_EN) begin : g_bcast
         assign inval_kind = (dir_copies > COPIES_W'(BCAST_MIN)) ? KIND_BCAST : KIND_MCAST;
      end else begin : g_mcast_only
         assign inval_kind = KIND_MCAST;
      end
   endgenerate

   always_comb begin
      if (op_q) begin
         need     = dir_hit && dir_dirty;
         kind_sel = KIND_SYNC;
      end else begin
         need     = dir_hit && (dir_copies != '0);
         kind_sel = inval_kind;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= WS_IDLE;
         lines_q <= '0;
         addr_q  <= '0;
         kind_q  <= KIND_MCAST;
         op_q    <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            WS_IDLE: if (start_go) begin
               st_q    <= WS_LOOP;
               lines_q <= line_total;
               addr_q  <= base_addr;
               op_q    <= op_sync;
            end
            WS_LOOP: begin
               if (lines_q != '0) st_q <= WS_LOOKUP;
               else if (pending_zero) begin
                  st_q   <= WS_IDLE;
                  done_q <= 1'b1;
               end
            end
            WS_LOOKUP: if (dir_ack) begin
               if (need) begin
                  kind_q <= kind_sel;
                  st_q   <= WS_ISSUE;
               end else begin
                  lines_q <= lines_q - LINES_W'(1);
                  addr_q  <= addr_q + STEP;
                  st_q    <= WS_LOOP;
               end
            end
            WS_ISSUE: if (txn_ready) begin
               lines_q <= lines_q - LINES_W'(1);
               addr_q  <= addr_q + STEP;
               st_q    <= WS_LOOP;
            end
            default: st_q <= WS_IDLE;
         endcase
      end
   end

   assign busy       = (st_q != WS_IDLE);
   assign dir_req    = (st_q == WS_LOOKUP);
   assign dir_addr   = addr_q;
   assign txn_valid  = (st_q == WS_ISSUE);
   assign txn_addr   = addr_q;
   assign txn_kind   = kind_q;
   assign issue_fire = txn_valid && txn_ready;
   assign lines_left = lines_q;
   assign done       = done_q;

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_addr) && $stable(txn_kind)));
   assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && lines_left == '0));
   assert_done_drained_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && lines_left == '0 && !pending_zero) |=> !done);
   assert_issue_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      issue_fire |=> (lines_left == $past(lines_left) - LINES_W'(1)));
   assert_miss_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_req && dir_ack && !dir_hit) |=> !txn_valid);
   assert_sync_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && op_q) |-> (txn_kind == KIND_SYNC));

endmodule

// File: rtl/range_maint_seq.sv
module range_maint_seq
   import rms_pkg::*;
#(
   parameter int ADDR_W     = 40,
   parameter int LEN_W      = 32,
   parameter int LINE_WORDS = 16,
   parameter int COPIES_W   = 8,
   parameter int BCAST_MIN  = 4,
   parameter bit BCAST_EN   = 1'b1,
   parameter int PEND_W     = 8,
   localparam int LINE_SH   = $clog2(LINE_WORDS * 4),
   localparam int LINES_W   = LEN_W - LINE_SH + 1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wr_en,
   input  logic [2:0]          cfg_wr_sel,
   input  logic [31:0]         cfg_wr_data,
   output logic                cfg_reject,
   output logic                dir_req,
   output logic [ADDR_W-1:0]   dir_addr,
   input  logic                dir_ack,
   input  logic                dir_hit,
   input  logic [COPIES_W-1:0] dir_copies,
   input  logic                dir_dirty,
   output logic                txn_valid,
   input  logic                txn_ready,
   output logic [ADDR_W-1:0]   txn_addr,
   output logic [1:0]          txn_kind,
   input  logic                rsp_inval_done,
   input  logic                rsp_sync_done,
   output logic                active,
   output logic                done,
   output logic [LINES_W-1:0]  lines_left,
   output logic [PEND_W-1:0]   pending
);

   initial begin
      assert (LINE_WORDS > 0 && (LINE_WORDS & (LINE_WORDS - 1)) == 0)
         else $error("LINE_WORDS must be a power of two");
      assert (ADDR_W >= 32 && ADDR_W <= 64) else $error("ADDR_W out of range");
      assert (LEN_W > LINE_SH && LEN_W <= 32) else $error("LEN_W out of range");
      assert (PEND_W >= 2) else $error("PEND_W too small");
      assert (BCAST_MIN < (1 << COPIES_W)) else $error("BCAST_MIN exceeds copy range");
   end

   logic               start_go;
   logic               op_sync;
   logic [ADDR_W-1:0]  base_addr;
   logic [LINES_W-1:0] line_total;
   logic               busy;
   logic               issue_fire;
   logic               pend_zero;

   rms_cfg_regs #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W),
      .LINE_SH(LINE_SH),
      .LINES_W(LINES_W)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr_en),
      .wr_sel    (cfg_wr_sel),
      .wr_data   (cfg_wr_data),
      .busy      (busy),
      .start_go  (start_go),
      .reject    (cfg_reject),
      .op_sync   (op_sync),
      .base_addr (base_addr),
      .line_total(line_total)
   );

   rms_walker #(
      .ADDR_W   (ADDR_W),
      .LINE_SH  (LINE_SH),
      .LINES_W  (LINES_W),
      .COPIES_W (COPIES_W),
      .BCAST_MIN(BCAST_MIN),
      .BCAST_EN (BCAST_EN)
   ) u_walk (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_go    (start_go),
      .op_sync     (op_sync),
      .base_addr   (base_addr),
      .line_total  (line_total),
      .pending_zero(pend_zero),
      .dir_ack     (dir_ack),
      .dir_hit     (dir_hit),
      .dir_copies  (dir_copies),
      .dir_dirty   (dir_dirty),
      .txn_ready   (txn_ready),
      .busy        (busy),
      .dir_req     (dir_req),
      .dir_addr    (dir_addr),
      .txn_valid   (txn_valid),
      .txn_addr    (txn_addr),
      .txn_kind    (txn_kind),
      .issue_fire  (issue_fire),
      .lines_left  (lines_left),
      .done        (done)
   );

   rms_resp_counter #(.W(PEND_W)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (start_go),
      .inc    (issue_fire),
      .dec_a  (rsp_inval_done),
      .dec_b  (rsp_sync_done),
      .count  (pending),
      .is_zero(pend_zero)
   );

   assign active = busy;

   assert_start_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_go |=> (active && pending == '0 && lines_left == $past(line_total)));
   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: tb/test_range_maint_seq.sv
module test_range_maint_seq;

   localparam int ADDR_W = 40, LEN_W = 32, LINE_WORDS = 4, COPIES_W = 4;
   localparam int BCAST_MIN = 3, PEND_W = 6;
   localparam int LINES_W = LEN_W - 4 + 1;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, cfg_wr_en, cfg_reject, dir_req, dir_ack, dir_hit, dir_dirty;
   logic [2:0] cfg_wr_sel;
   logic [31:0] cfg_wr_data;
   logic [ADDR_W-1:0] dir_addr, txn_addr;
   logic [COPIES_W-1:0] dir_copies;
   logic txn_valid, txn_ready, rsp_inval_done, rsp_sync_done, active, done, ack_en;
   logic [1:0] txn_kind;
   logic [LINES_W-1:0] lines_left;
   logic [PEND_W-1:0] pending;

   int checks = 0, fails = 0;
   bit finished = 0;

   range_maint_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_WORDS(LINE_WORDS),
      .COPIES_W(COPIES_W), .BCAST_MIN(BCAST_MIN), .BCAST_EN(1'b1), .PEND_W(PEND_W))
   i_range_maint_seq (.*);

   function automatic logic [7:0] lidx(logic [39:0] a);
      return a[11:4];
   endfunction
   function automatic bit m_hit(logic [39:0] a);
      return (lidx(a) % 3) != 0;
   endfunction
   function automatic logic [3:0] m_copies(logic [39:0] a);
      return 4'(lidx(a) % 6);
   endfunction
   function automatic bit m_dirty(logic [39:0] a);
      return lidx(a)[0] ^ lidx(a)[2];
   endfunction
   function automatic bit m_need(logic [39:0] a, bit op);
      if (op) return m_hit(a) && m_dirty(a);
      return m_hit(a) && (m_copies(a) != 0);
   endfunction
   function automatic logic [1:0] m_kind(logic [39:0] a, bit op);
      if (op) return 2'd2;
      return (m_copies(a) > BCAST_MIN) ? 2'd1 : 2'd0;
   endfunction

   assign dir_ack    = dir_req && ack_en;
   assign dir_hit    = m_hit(dir_addr);
   assign dir_copies = m_copies(dir_addr);
   assign dir_dirty  = m_dirty(dir_addr);

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] sel, logic [31:0] data);
      cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic run_cmd(logic [39:0] base, int len, bit op, int mode, int rej_at);
      logic [39:0] al = {base[39:4], 4'h0};
      int nlines = (len + 15) / 16;
      int exp_cnt = 0, k = 0, issued = 0, pm = 0, cyc = 0;
      bit fin = 0, fire, dec, held = 0, rej_pend = 0;
      logic [39:0] held_addr;
      for (int i = 0; i < nlines; i++) if (m_need(al + 40'(i * 16), op)) exp_cnt++;
      wr(3'd0, base[31:0]); wr(3'd1, {24'h0, base[39:32]});
      wr(3'd2, 32'(len)); wr(3'd3, {31'h0, op}); wr(3'd4, 32'h1);
      chk(lines_left == LINES_W'(nlines), "R1", "line count", lines_left, nlines);
      chk(pending == 0 && active, "R2", "pending cleared on start", pending, 0);
      while (!fin && cyc < 4000) begin
         txn_ready = (mode == 0) ? 1'b1 : ((cyc + mode) % 3 != 0);
         ack_en = (mode == 2) ? (cyc % 2 == 0) : 1'b1;
         rsp_inval_done = (pm > 0) && (cyc % 3 == 0);
         rsp_sync_done  = (pm > 0) && ((cyc + mode) % 2 == 0);
         rej_pend = (cyc == rej_at) && active;
         if (rej_pend) begin cfg_wr_en = 1'b1; cfg_wr_sel = 3'd4; cfg_wr_data = 32'h1; end
         #1;
         if (held) chk(txn_valid && txn_addr == held_addr, "R8", "held txn", txn_addr, held_addr);
         held = txn_valid && !txn_ready; held_addr = txn_addr;
         fire = txn_valid && txn_ready;
         if (fire) begin
            while (k < nlines && !m_need(al + 40'(k * 16), op)) k++;
            chk(txn_addr == al + 40'(k * 16), "R2", "txn address order", txn_addr, al + 40'(k * 16));
            chk(txn_kind == m_kind(al + 40'(k * 16), op), "R5", "txn kind",
                txn_kind, m_kind(al + 40'(k * 16), op));
            k++; issued++;
         end
         dec = rsp_inval_done || rsp_sync_done;
         pm = pm + (fire ? 1 : 0) - (dec ? 1 : 0);
         @(negedge clk);
         cfg_wr_en = 1'b0;
         if (rej_pend) chk(cfg_reject == 1'b1, "R7", "start while busy refused", cfg_reject, 1);
         chk(pending == PEND_W'(pm), "R3", "outstanding count", pending, pm);
         if (done) begin
            fin = 1;
            chk(issued == exp_cnt, "R4", "transactions issued", issued, exp_cnt);
            chk(pm == 0 && lines_left == 0 && !active, "R6", "drained at done", pm, 0);
         end
         cyc++;
      end
      rsp_inval_done = 0; rsp_sync_done = 0; txn_ready = 0;
      chk(fin, "R6", "walk completed", fin, 1);
      @(negedge clk);
      chk(!done, "R6", "done single cycle", done, 0);
   endtask

   initial begin
      #(8 * 190000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int lens[9] = '{0, 1, 15, 16, 17, 32, 33, 100, 255};
      logic [39:0] bases[2] = '{40'h12_3456_7800, 40'h00_0000_0ff5};
      int run = 0;
      rst_n = 0; cfg_wr_en = 0; cfg_wr_sel = 0; cfg_wr_data = 0;
      txn_ready = 0; rsp_inval_done = 0; rsp_sync_done = 0; ack_en = 1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(!active && !done && !txn_valid && !dir_req && !cfg_reject, "R9", "reset outputs", active, 0);
      chk(pending == 0 && lines_left == 0, "R9", "reset counters", pending, 0);
      for (int op = 0; op < 2; op++)
         for (int b = 0; b < 2; b++)
            for (int li = 0; li < 9; li++) begin
               run_cmd(bases[b], lens[li], op[0], run % 3, (lens[li] >= 100) ? 3 : -1);
               run++;
            end
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule